// File: doc/BRIEF.md
# Register-Bank I2C Target with Pointer Auto-Increment

This block lets an I2C master reach a bank of 8-bit configuration registers through an 8-bit register pointer. The block watches oversampled SCL and SDA lines and answers only to one fixed 7-bit device address. A write transaction carries the pointer and then one or more data bytes. The data bytes are not written to the bank at once: they are held in a small staging buffer and are written out only when a STOP ends the transaction. A read starts with a short write that carries only the pointer. The master then sends a repeated START with the read bit, and the block returns bytes from consecutive addresses until the master declines a byte.

The register bank sits outside the block. On the write side the block gives a one-cycle write strobe with an address and a data byte. On the read side it shows the current pointer as the read address, takes the read data back combinationally, and pulses a read strobe each time it captures a byte. SDA is open-drain: the block only pulls the line low, through `sda_oe`.

A low level on `rst_n` is the standby state. After `rst_n` goes high, the block stays silent for a set number of clock cycles, which cover the 200 µs settling window.

Top module: `i2c_regslave`

## Requirements
- R1: Only the device address 1001001 (the first byte 0x92 for a write, 0x93 for a read) gets an ACK. Any other address gets a NACK. The block then leaves SDA released until the next START or STOP, so no later byte of that transaction is acknowledged.
- R2: In a write transaction to the device address, the address byte, the pointer byte and each accepted data byte are acknowledged (SDA is low in the ninth clock). Data byte k (counting from 0) is written to address pointer+k.
- R3: No write strobe comes out before the STOP of a write transaction. After that STOP, all staged bytes are written, one per clock cycle and in ascending address order, within 20 clock cycles.
- R4: A repeated START before any STOP discards the data bytes staged so far. Their registers keep their old values.
- R5: The pointer wraps from 0xFF to 0x00 during auto-increment, on both writes and reads.
- R6: A read is a write of the pointer alone, then a repeated START with 0x93. The block returns the register at the pointer MSB first, and one more register at each following address every time the master ACKs.
- R7: When the master NACKs a read byte, the block releases SDA and fetches no more bytes until the next START or STOP.
- R8: A write burst holds at most BURST_MAX data bytes (4 by default). Any further byte gets a NACK and is never written, while the bytes already accepted are still written at STOP.
- R9: While `rst_n` is low, and for GUARD_CYCLES clock cycles after it rises, the block acknowledges nothing and writes nothing.
- R10: The block only pulls SDA low and never drives it high. SDA is released after reset and after every STOP.
- R11: The pointer keeps its value between transactions, so a read with no pointer write goes on from the address after the last byte read or written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the I2C lines |
| rst_n | input | 1 | Synchronous active-low reset; low means standby |
| scl_in | input | 1 | SCL line level (asynchronous) |
| sda_in | input | 1 | SDA line level (asynchronous) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| rd_addr | output | 8 | Register address for read data (the current pointer) |
| rd_data | input | 8 | Register contents at rd_addr, combinational |
| rd_en | output | 1 | One-cycle pulse when a read byte is captured |
| wr_en | output | 1 | One-cycle write strobe into the register bank |
| wr_addr | output | 8 | Register address for wr_data |
| wr_data | output | 8 | Data byte to write |

## Verification
A wrong pointer, or a wrong staging index, shows up as a wrong byte in the register bank after the STOP that commits it. The bench finds it on the next read-back, which sweeps all 256 addresses. A wrong protocol state shows up within one bit time as an ACK in the wrong ninth clock, as a missing ACK, or as SDA held low after a NACK. The bench samples each of these bit by bit. A write that comes out early or late shows as a change in the write-strobe count before the STOP, or as a missing count within 20 cycles after it.

// File: rtl/i2c_regslave_pkg.sv
// Package: shared types and constants for the register-bank I2C target.
// Assumes 8-bit pointers and 8-bit register data.
package i2c_regslave_pkg;

    // Fixed 7-bit device address the target answers to
    localparam logic [6:0] DEV_ADDR = 7'b1001001;

    // Protocol sequencer states
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_IGNORE
    } slv_state_e;

endpackage

// File: rtl/i2c_bus_sync.sv
// Module: two-flop synchronisers for SCL and SDA, plus edge and bus-condition detection.
// Assumes the system clock runs many times faster than SCL, and that SDA changes
// only while SCL is low, except at START and STOP.
module i2c_bus_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_bit,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [1:0] scl_pipe;
    logic [1:0] sda_pipe;
    logic       scl_prev;
    logic       sda_prev;

    // Synchronise both lines and keep their previous synchronised values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= 2'b11;
            sda_pipe <= 2'b11;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[0], scl_in};
            sda_pipe <= {sda_pipe[0], sda_in};
            scl_prev <= scl_pipe[1];
            sda_prev <= sda_pipe[1];
        end
    end

    assign sda_bit   = sda_pipe[1];
    assign scl_rise  = scl_pipe[1] & ~scl_prev;
    assign scl_fall  = ~scl_pipe[1] & scl_prev;
    assign start_det = scl_pipe[1] & scl_prev & sda_prev & ~sda_pipe[1];
    assign stop_det  = scl_pipe[1] & scl_prev & ~sda_prev & sda_pipe[1];

endmodule

// File: rtl/i2c_wr_stage.sv
// Module: holds write-burst bytes until STOP, then writes them to the bank one per cycle.
// Assumes no new byte arrives while a drain is running (the bus is far slower than the drain).
module i2c_wr_stage #(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic [AW-1:0] push_addr,
    input  logic          clear,
    input  logic          commit,
    output logic          full,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [CW-1:0] count;
    logic [CW-1:0] idx;
    logic [AW-1:0] base;
    logic          busy;

    // Fill, discard and drain control for the staging buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            idx   <= '0;
            base  <= '0;
            busy  <= 1'b0;
        end else if (busy) begin
            idx <= idx + CW'(1);
            if (idx == count - CW'(1)) begin
                busy  <= 1'b0;
                count <= '0;
            end
        end else if (commit && count != '0) begin
            busy <= 1'b1;
            idx  <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (push && !full) begin
            if (count == '0) begin
                base <= push_addr;
            end
            count <= count + CW'(1);
        end
    end

    // Data storage, written only while filling
    always_ff @(posedge clk) begin
        if (!busy && !commit && !clear && push && !full) begin
            mem[count[IW-1:0]] <= push_data;
        end
    end

    assign full    = (count == CW'(DEPTH));
    assign wr_en   = busy;
    assign wr_addr = base + AW'(idx);
    assign wr_data = mem[idx[IW-1:0]];

    AST_STAGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R8
    AST_DRAIN_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + AW'(1))); // R3

endmodule

// File: rtl/i2c_slave_fsm.sv
// Module: byte-level protocol sequencer. It handles address match, pointer load,
// write staging requests, read shifting and ACK/NACK driving.
// Assumes the edge and condition strobes come from i2c_bus_sync, and that rd_data
// is valid in the same cycle as rd_addr.
module i2c_slave_fsm
    import i2c_regslave_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_en,
    input  logic       sda_bit,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    input  logic       stg_full,
    output logic       sda_oe,
    output logic       rd_en,
    output logic [7:0] ptr,
    output logic       push,
    output logic [7:0] push_data,
    output logic [7:0] push_addr,
    output logic       stg_clear,
    output logic       commit
);

    slv_state_e state;
    logic [3:0] cnt;
    logic [7:0] shreg;
    logic       rw;
    logic       mack;

    // Sequence the transaction one SCL edge at a time
    always_ff @(posedge clk) begin
        push      <= 1'b0;
        rd_en     <= 1'b0;
        commit    <= 1'b0;
        stg_clear <= 1'b0;
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            ptr       <= '0;
            sda_oe    <= 1'b0;
            rw        <= 1'b0;
            mack      <= 1'b0;
            push_data <= '0;
            push_addr <= '0;
        end else if (!bus_en) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else if (start_det) begin
            state     <= ST_ADDR;
            cnt       <= '0;
            sda_oe    <= 1'b0;
            stg_clear <= 1'b1;
        end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
            commit <= 1'b1;
        end else begin
            unique case (state)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg <= {shreg[6:0], sda_bit};
                        cnt   <= cnt + 4'd1;
                    end else if (scl_fall && cnt == 4'd8) begin
                        if (state == ST_ADDR) begin
                            if (shreg[7:1] == DEV_ADDR) begin
                                sda_oe <= 1'b1;
                                rw     <= shreg[0];
                                state  <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end else if (state == ST_PTR) begin
                            ptr    <= shreg;
                            sda_oe <= 1'b1;
                            state  <= ST_PTR_ACK;
                        end else if (!stg_full) begin
                            push      <= 1'b1;
                            push_data <= shreg;
                            push_addr <= ptr;
                            ptr       <= ptr + 8'd1;
                            sda_oe    <= 1'b1;
                            state     <= ST_WDATA_ACK;
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            shreg  <= rd_data;
                            rd_en  <= 1'b1;
                            ptr    <= ptr + 8'd1;
                            sda_oe <= !rd_data[7];
                            state  <= ST_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_PTR;
                        end
                    end
                end
                ST_PTR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        state  <= ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (cnt == 4'd7) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RDATA_ACK;
                        end else begin
                            shreg  <= {shreg[6:0], 1'b0};
                            sda_oe <= !shreg[6];
                            cnt    <= cnt + 4'd1;
                        end
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_rise) begin
                        mack <= !sda_bit;
                    end else if (scl_fall) begin
                        if (mack) begin
                            cnt    <= '0;
                            shreg  <= rd_data;
                            rd_en  <= 1'b1;
                            ptr    <= ptr + 8'd1;
                            sda_oe <= !rd_data[7];
                            state  <= ST_RDATA;
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    AST_IGNORE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_oe); // R1
    AST_PUSH_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> sda_oe); // R2
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe); // R10
    AST_GUARD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |=> !sda_oe); // R9

endmodule

// File: rtl/i2c_regslave.sv
// Module: top of the register-bank I2C target. It ties the line sampler, the sequencer
// and the write staging together, and holds the bus closed for a guard time after standby.
// Assumes rst_n low is standby and that rd_data follows rd_addr combinationally.
module i2c_regslave #(
    parameter int GUARD_CYCLES = 40000,
    parameter int BURST_MAX    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    output logic [7:0] rd_addr,
    input  logic [7:0] rd_data,
    output logic       rd_en,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data
);

    localparam int GW = $clog2(GUARD_CYCLES + 1);

    logic [GW-1:0] guard_cnt;
    logic          bus_en;
    logic          sda_bit, scl_rise, scl_fall, start_det, stop_det;
    logic          push, stg_clear, commit, stg_full;
    logic [7:0]    push_data, push_addr;

    // Count out the settling window after standby ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            guard_cnt <= '0;
        end else if (!bus_en) begin
            guard_cnt <= guard_cnt + GW'(1);
        end
    end

    assign bus_en = (guard_cnt == GW'(GUARD_CYCLES));

    i2c_bus_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_bit   (sda_bit),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_slave_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .sda_bit   (sda_bit),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .stg_full  (stg_full),
        .sda_oe    (sda_oe),
        .rd_en     (rd_en),
        .ptr       (rd_addr),
        .push      (push),
        .push_data (push_data),
        .push_addr (push_addr),
        .stg_clear (stg_clear),
        .commit    (commit)
    );

    i2c_wr_stage #(
        .DEPTH (BURST_MAX),
        .AW    (8),
        .DW    (8)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .push_addr (push_addr),
        .clear     (stg_clear),
        .commit    (commit),
        .full      (stg_full),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    AST_NO_WR_IN_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |-> !wr_en); // R9

endmodule

// File: tb/i2c_regslave_tb.sv
// Bench: bit-banged I2C master against a behavioural register bank. Expected bank
// contents are computed arithmetically from the requirements.
module i2c_regslave_tb;

    localparam int Q     = 4;
    localparam int GUARD = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe, rd_en, wr_en;
    logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
    logic sda_line;

    logic [7:0] bmem [256];
    logic [7:0] exp_mem [256];
    int nchk = 0;
    int nerr = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    int oe_cnt = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign sda_line = !(m_low || sda_oe);
    assign rd_data  = bmem[rd_addr];

    i2c_regslave #(.GUARD_CYCLES(GUARD), .BURST_MAX(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
        .sda_oe(sda_oe), .rd_addr(rd_addr), .rd_data(rd_data), .rd_en(rd_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // Behavioural register bank plus strobe counters
    always @(posedge clk) begin
        if (wr_en) begin
            bmem[wr_addr] <= wr_data;
            wr_cnt <= wr_cnt + 1;
        end
        if (rd_en) rd_cnt <= rd_cnt + 1;
        if (sda_oe) oe_cnt <= oe_cnt + 1;
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int expv);
        nchk++;
        if (act != expv) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic bus_bit(input logic b, output logic r);
        m_low = !b;
        tick(Q);
        scl = 1'b1;
        tick(Q);
        r = sda_line;
        tick(Q);
        scl = 1'b0;
        tick(Q);
    endtask

    task automatic start_c();
        m_low = 1'b0;
        tick(Q);
        scl = 1'b1;
        tick(Q);
        m_low = 1'b1;
        tick(Q);
        scl = 1'b0;
        tick(Q);
    endtask

    task automatic stop_c();
        m_low = 1'b1;
        tick(Q);
        scl = 1'b1;
        tick(Q);
        m_low = 1'b0;
        tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic r;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], r);
        bus_bit(1'b1, r);
        acked = !r;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, r);
            d[i] = r;
        end
        bus_bit(!give_ack, r);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] d;
        int w0;
        int r0;
        int o0;
        for (int i = 0; i < 256; i++) begin
            bmem[i] = 8'h00;
            exp_mem[i] = 8'h00;
        end
        tick(8);
        chk("R10 reset sda_oe", sda_oe, 0);
        chk("R10 reset wr_en", wr_en, 0);
        rst_n = 1'b1;

        // R9: an address byte inside the guard window is not acknowledged
        start_c();
        send_byte(8'h92, a);
        chk("R9 guard no ack", a, 0);
        stop_c();
        tick(GUARD + 100);
        chk("R9 guard no write", wr_cnt, 0);

        // R2/R3: sweep every address with four-byte bursts
        for (int blk = 0; blk < 64; blk++) begin
            start_c();
            send_byte(8'h92, a);
            chk("R2 addr ack", a, 1);
            send_byte(8'(blk * 4), a);
            chk("R2 ptr ack", a, 1);
            for (int k = 0; k < 4; k++) begin
                send_byte(pat(blk * 4 + k), a);
                chk("R2 data ack", a, 1);
                exp_mem[blk * 4 + k] = pat(blk * 4 + k);
            end
            w0 = wr_cnt;
            chk("R3 no write before stop", wr_cnt, blk * 4);
            stop_c();
            tick(20);
            chk("R3 commit count", wr_cnt - w0, 4);
            chk("R10 released after stop", sda_oe, 0);
        end

        // R6: read back everything in eight-byte bursts
        for (int blk = 0; blk < 32; blk++) begin
            start_c();
            send_byte(8'h92, a);
            send_byte(8'(blk * 8), a);
            start_c();
            send_byte(8'h93, a);
            chk("R6 read addr ack", a, 1);
            for (int k = 0; k < 8; k++) begin
                recv_byte(k != 7, d);
                chk("R6 read data", d, exp_mem[blk * 8 + k]);
            end
            stop_c();
        end

        // R5: write and read across the 0xFF -> 0x00 wrap
        start_c();
        send_byte(8'h92, a);
        send_byte(8'hFE, a);
        for (int k = 0; k < 4; k++) begin
            send_byte(8'(8'hC0 + k), a);
            exp_mem[(254 + k) & 255] = 8'(8'hC0 + k);
        end
        stop_c();
        tick(20);
        chk("R5 wrap write FF", bmem[255], 8'hC1);
        chk("R5 wrap write 00", bmem[0], 8'hC2);
        chk("R5 wrap write 01", bmem[1], 8'hC3);
        start_c();
        send_byte(8'h92, a);
        send_byte(8'hFF, a);
        start_c();
        send_byte(8'h93, a);
        for (int k = 0; k < 3; k++) begin
            recv_byte(k != 2, d);
            chk("R5 wrap read", d, exp_mem[(255 + k) & 255]);
        end
        stop_c();

        // R4: repeated START discards staged bytes
        start_c();
        send_byte(8'h92, a);
        send_byte(8'h10, a);
        send_byte(8'hAA, a);
        start_c();
        send_byte(8'h92, a);
        send_byte(8'h20, a);
        send_byte(8'h55, a);
        stop_c();
        exp_mem[8'h20] = 8'h55;
        tick(20);
        chk("R4 discarded byte kept old", bmem[8'h10], exp_mem[8'h10]);
        chk("R4 later write done", bmem[8'h20], 8'h55);

        // R8: bytes past the staging depth are NACKed and dropped
        start_c();
        send_byte(8'h92, a);
        send_byte(8'h30, a);
        for (int k = 0; k < 6; k++) begin
            send_byte(8'(8'h70 + k), a);
            chk("R8 burst ack", a, (k < 4) ? 1 : 0);
            if (k < 4) exp_mem[8'h30 + k] = 8'(8'h70 + k);
        end
        stop_c();
        tick(20);
        for (int k = 0; k < 6; k++) chk("R8 burst contents", bmem[8'h30 + k], exp_mem[8'h30 + k]);

        // R1: a foreign address is NACKed and the rest of the transaction ignored
        o0 = oe_cnt;
        start_c();
        send_byte(8'h90, a);
        chk("R1 foreign addr nack", a, 0);
        send_byte(8'h00, a);
        chk("R1 later byte nack", a, 0);
        stop_c();
        chk("R1 sda never pulled", oe_cnt - o0, 0);
        start_c();
        send_byte(8'h93 ^ 8'h02, a);
        chk("R1 foreign read nack", a, 0);
        stop_c();

        // R7/R11: NACK ends the read, pointer persists to next transaction
        start_c();
        send_byte(8'h92, a);
        send_byte(8'h40, a);
        start_c();
        send_byte(8'h93, a);
        recv_byte(1'b1, d);
        chk("R6 read 40", d, exp_mem[8'h40]);
        recv_byte(1'b0, d);
        chk("R6 read 41", d, exp_mem[8'h41]);
        r0 = rd_cnt;
        recv_byte(1'b0, d);
        chk("R7 released after nack", d, 8'hFF);
        chk("R7 no fetch after nack", rd_cnt - r0, 0);
        stop_c();
        start_c();
        send_byte(8'h93, a);
        recv_byte(1'b0, d);
        chk("R11 pointer persists", d, exp_mem[8'h42]);
        stop_c();
        tick(10);
        chk("R10 idle released", sda_oe, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule